// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and End-of-Interrupt Controller

This block serves one processor target of an interrupt controller. A source unit sends raise requests, each carrying a source index and that source's priority. The block keeps two sets of sources, each entry holding its own priority. The first set holds sources that are raised and wait for the processor. The second set holds sources the processor has taken and not yet retired. The block compares the best waiting source with the task priority and with the best source in service, and from that it drives the processor interrupt line.

The processor uses a small register port with four addresses:
- A task priority register, which resets to 0xF.
- An acknowledge register. A read returns a vector and moves the selected source into service.
- An end-of-interrupt register. A write retires the top source in service.
- An identity register, which is read-only.

The block always presents the index of its best raised source on `sel_idx`. The source unit answers that index combinationally with four values: the source's activity bit, its sense mode, its current priority and its vector.

On every acknowledge that picks a source, the block issues a one-cycle clear pulse back to the source unit. The pulse names the source and says whether its activity bit and its pending flag must be cleared.

Top module: `cpuack_ctrl`

## Requirements
- R1: After reset the task priority reads 0xF, both sets are empty and `cpu_irq` is low.
- R2: The best member of a set is the one with the highest priority. Among equal priorities the lowest index wins.
- R3: A raise is accepted only if its priority is strictly above the task priority and the index is not already in the raised set. A rejected raise changes nothing, and in particular does not change the stored priority.
- R4: `cpu_irq` is high exactly when a raised source exists whose priority is above the task priority and also above the best in-service priority. An empty in-service set counts as lower than any priority.
- R5: A read of address 1 (acknowledge) with no raised source returns `spur_vec` and issues no clear pulse.
- R6: In this requirement, "selected source" means the best raised source. An acknowledge read behaves as follows:
  - If the selected source is active and its `sel_prio` is above the task priority, the read returns `sel_vec`.
  - In that case the source enters the in-service set, using priority `sel_prio`.
  - In every case, the source leaves the raised set and `clr_valid` pulses with `clr_idx` equal to its index.
- R7: If the selected source is inactive, or its `sel_prio` is not above the task priority, the acknowledge returns `spur_vec`, asserts `clr_active`, and the source does not enter service.
- R8: When the selected source is edge-sensitive (`sel_edge`=1), the clear pulse asserts both `clr_active` and `clr_pending`.
- R9: A write to address 2 (end of interrupt) removes the best in-service source. After that, `cpu_irq` follows R4 against the remaining in-service set.
- R10: An end-of-interrupt write while the in-service set is empty has no effect.
- R11: A read of address 3 returns the parameter `CPU_ID`. Writes to address 3 are ignored.
- R12: A write to address 0 loads the low `PRIO_W` bits into the task priority. A read of address 0 returns the task priority zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raise_valid | input | 1 | Raise request strobe |
| raise_idx | input | IDX_W | Index of the raised source |
| raise_prio | input | PRIO_W | Priority of the raised source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 task priority, 1 acknowledge, 2 end of interrupt, 3 identity |
| reg_wdata | input | VEC_W | Write data |
| reg_rdata | output | VEC_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | High one cycle after a read strobe |
| spur_vec | input | VEC_W | Spurious vector value |
| sel_idx | output | IDX_W | Index of the current best raised source |
| sel_active | input | 1 | Activity bit of source sel_idx |
| sel_edge | input | 1 | Source sel_idx is edge-sensitive |
| sel_prio | input | PRIO_W | Current priority of source sel_idx |
| sel_vec | input | VEC_W | Vector of source sel_idx |
| clr_valid | output | 1 | Clear pulse for source clr_idx |
| clr_idx | output | IDX_W | Source to clear |
| clr_active | output | 1 | Clear that source's activity bit |
| clr_pending | output | 1 | Clear that source's pending flag |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
Results arrive on two timescales:
- `cpu_irq` is a function of registered state only. It settles one clock edge after the raise, write or acknowledge that changed that state.
- Read data, `reg_rvalid` and the clear pulse are registered. They appear one edge after the read strobe and last one cycle.

The bench drives every input on a falling edge. It checks `cpu_irq` at the falling edge that follows the capturing rising edge. A monitor compares read data and clear pulses at the falling edge where `reg_rvalid` is high. The monitor pops the expected values in order from queues that the read task filled when it issued the strobe.

// File: rtl/cpuack_pkg.sv
package cpuack_pkg;
   typedef enum logic [1:0] {
      REG_TPRI = 2'd0,
      REG_ACK  = 2'd1,
      REG_EOI  = 2'd2,
      REG_WHO  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/cpuack_pick.sv
module cpuack_pick #(
   parameter int N  = 8,
   parameter int PW = 4,
   parameter int IW = 3
) (
   input  logic [N-1:0]    member,
   input  logic [N*PW-1:0] prio_flat,
   output logic            found,
   output logic [IW-1:0]   best_idx,
   output logic [PW-1:0]   best_prio
);
   // scan upward, replace only on strictly higher priority: lowest index wins ties
   always_comb begin
      found     = 1'b0;
      best_idx  = '0;
      best_prio = '0;
      for (int i = 0; i < N; i++) begin
         if (member[i] && (!found || prio_flat[i*PW +: PW] > best_prio)) begin
            found     = 1'b1;
            best_idx  = IW'(i);
            best_prio = prio_flat[i*PW +: PW];
         end
      end
   end
endmodule

// File: rtl/cpuack_set.sv
module cpuack_set #(
   parameter int N  = 8,
   parameter int PW = 4,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          add_en,
   input  logic [IW-1:0] add_idx,
   input  logic [PW-1:0] add_prio,
   input  logic          del_en,
   input  logic [IW-1:0] del_idx,
   output logic [N-1:0]  members,
   output logic          top_found,
   output logic [IW-1:0] top_idx,
   output logic [PW-1:0] top_prio
);
   logic [N*PW-1:0] prio_flat;

   for (genvar g = 0; g < N; g++) begin : g_entry
      logic          in_q;
      logic [PW-1:0] pr_q;
      logic          hit_add, hit_del;
      assign hit_add = add_en && (add_idx == IW'(g));
      assign hit_del = del_en && (del_idx == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_q <= 1'b0;
            pr_q <= '0;
         end else if (hit_add) begin
            in_q <= 1'b1;
            pr_q <= add_prio;
         end else if (hit_del) begin
            in_q <= 1'b0;
         end
      end
      assign members[g]            = in_q;
      assign prio_flat[g*PW +: PW] = pr_q;
   end

   cpuack_pick #(.N(N), .PW(PW), .IW(IW)) u_pick (
      .member    (members),
      .prio_flat (prio_flat),
      .found     (top_found),
      .best_idx  (top_idx),
      .best_prio (top_prio)
   );
endmodule

// File: rtl/cpuack_ctrl.sv
module cpuack_ctrl
   import cpuack_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 4,
   parameter int VEC_W   = 8,
   parameter int CPU_ID  = 2,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raise_valid,
   input  logic [IDX_W-1:0] raise_idx,
   input  logic [PRIO_W-1:0] raise_prio,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [VEC_W-1:0] reg_wdata,
   output logic [VEC_W-1:0] reg_rdata,
   output logic             reg_rvalid,
   input  logic [VEC_W-1:0] spur_vec,
   output logic [IDX_W-1:0] sel_idx,
   input  logic             sel_active,
   input  logic             sel_edge,
   input  logic [PRIO_W-1:0] sel_prio,
   input  logic [VEC_W-1:0] sel_vec,
   output logic             clr_valid,
   output logic [IDX_W-1:0] clr_idx,
   output logic             clr_active,
   output logic             clr_pending,
   output logic             cpu_irq
);
   localparam logic [PRIO_W-1:0] TPRI_RST = '1;

   if (NUM_SRC < 2) begin : g_bad_src
      $error("cpuack_ctrl: NUM_SRC must be at least 2");
   end
   if (PRIO_W < 1 || PRIO_W > VEC_W) begin : g_bad_prio
      $error("cpuack_ctrl: PRIO_W must lie in 1..VEC_W");
   end
   if (CPU_ID < 0 || CPU_ID >= (1 << VEC_W)) begin : g_bad_id
      $error("cpuack_ctrl: CPU_ID does not fit in VEC_W bits");
   end

   logic [PRIO_W-1:0] tpri_q;
   logic [NUM_SRC-1:0] r_members, s_members;
   logic              r_found, s_found;
   logic [IDX_W-1:0]  r_idx, s_idx;
   logic [PRIO_W-1:0] r_prio, s_prio;

   logic ack_go, eoi_go, ack_hit, ack_take, raise_ok;

   assign ack_go   = reg_rd && (reg_addr == REG_ACK);
   assign eoi_go   = reg_wr && (reg_addr == REG_EOI);
   assign ack_hit  = ack_go && r_found;
   assign ack_take = ack_hit && sel_active && (sel_prio > tpri_q);
   assign raise_ok = raise_valid && (raise_prio > tpri_q) && !r_members[raise_idx];

   cpuack_set #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_raised (
      .clk       (clk),
      .rst_n     (rst_n),
      .add_en    (raise_ok),
      .add_idx   (raise_idx),
      .add_prio  (raise_prio),
      .del_en    (ack_hit),
      .del_idx   (r_idx),
      .members   (r_members),
      .top_found (r_found),
      .top_idx   (r_idx),
      .top_prio  (r_prio)
   );

   cpuack_set #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_insvc (
      .clk       (clk),
      .rst_n     (rst_n),
      .add_en    (ack_take),
      .add_idx   (r_idx),
      .add_prio  (sel_prio),
      .del_en    (eoi_go && s_found),
      .del_idx   (s_idx),
      .members   (s_members),
      .top_found (s_found),
      .top_idx   (s_idx),
      .top_prio  (s_prio)
   );

   assign sel_idx = r_idx;
   assign cpu_irq = r_found && (r_prio > tpri_q) && (!s_found || r_prio > s_prio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tpri_q <= TPRI_RST;
      else if (reg_wr && reg_addr == REG_TPRI) tpri_q <= reg_wdata[PRIO_W-1:0];
   end

   logic [VEC_W-1:0] rd_next;
   always_comb begin
      unique case (reg_addr)
         REG_TPRI: rd_next = VEC_W'(tpri_q);
         REG_ACK:  rd_next = ack_take ? sel_vec : spur_vec;
         REG_EOI:  rd_next = '0;
         default:  rd_next = VEC_W'(CPU_ID);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata   <= '0;
         reg_rvalid  <= 1'b0;
         clr_valid   <= 1'b0;
         clr_idx     <= '0;
         clr_active  <= 1'b0;
         clr_pending <= 1'b0;
      end else begin
         reg_rvalid  <= reg_rd;
         if (reg_rd) reg_rdata <= rd_next;
         clr_valid   <= ack_hit;
         clr_idx     <= ack_hit ? r_idx : '0;
         clr_active  <= ack_hit && (sel_edge || !ack_take);
         clr_pending <= ack_hit && sel_edge;
      end
   end
endmodule

// File: rtl/cpuack_ctrl_chk.sv
module cpuack_ctrl_chk #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 4,
   parameter int VEC_W   = 8,
   parameter int CPU_ID  = 2,
   parameter int IDX_W   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic [1:0]       reg_addr,
   input logic [VEC_W-1:0] reg_wdata,
   input logic [VEC_W-1:0] reg_rdata,
   input logic             reg_rvalid,
   input logic [VEC_W-1:0] spur_vec,
   input logic             clr_valid,
   input logic [IDX_W-1:0] clr_idx,
   input logic             clr_active,
   input logic             clr_pending,
   input logic             cpu_irq,
   input logic             r_found,
   input logic [IDX_W-1:0] r_idx,
   input logic [PRIO_W-1:0] r_prio,
   input logic             s_found,
   input logic [NUM_SRC-1:0] s_members,
   input logic [PRIO_W-1:0] tpri_q
);
   // R4
   irq_has_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (r_found && r_prio > tpri_q));
   // R5
   empty_ack_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd1 && !r_found) |=> (reg_rdata == $past(spur_vec) && !clr_valid));
   // R6
   ack_clr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd1 && r_found) |=> (clr_valid && clr_idx == $past(r_idx)));
   // R8
   pend_implies_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pending |-> (clr_active && clr_valid));
   // R10
   eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd2 && !s_found && !reg_rd) |=> $stable(s_members));
   // R11
   who_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd3) |=> (reg_rvalid && reg_rdata == VEC_W'(CPU_ID)));
   // R12
   tpri_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0) |=> (tpri_q == $past(reg_wdata[PRIO_W-1:0])));
endmodule

bind cpuack_ctrl cpuack_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .CPU_ID(CPU_ID), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
   .spur_vec(spur_vec), .clr_valid(clr_valid), .clr_idx(clr_idx),
   .clr_active(clr_active), .clr_pending(clr_pending), .cpu_irq(cpu_irq),
   .r_found(r_found), .r_idx(r_idx), .r_prio(r_prio), .s_found(s_found),
   .s_members(s_members), .tpri_q(tpri_q)
);

// File: tb/cpuack_ctrl_test.sv
module cpuack_ctrl_test;
   localparam int NS = 8, PW = 4, VW = 8, ID = 2, IW = 3;
   localparam logic [VW-1:0] SPUR = 8'hA5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic raise_valid = 1'b0;
   logic [IW-1:0] raise_idx = '0;
   logic [PW-1:0] raise_prio = '0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [VW-1:0] reg_wdata = '0, reg_rdata;
   logic reg_rvalid;
   logic [IW-1:0] sel_idx, clr_idx;
   logic sel_active, sel_edge, clr_valid, clr_active, clr_pending, cpu_irq;
   logic [PW-1:0] sel_prio;
   logic [VW-1:0] sel_vec;

   logic          b_act [NS];
   logic          b_edge[NS];
   logic [PW-1:0] b_prio[NS];
   logic [VW-1:0] b_vec [NS];
   assign sel_active = b_act[sel_idx];
   assign sel_edge   = b_edge[sel_idx];
   assign sel_prio   = b_prio[sel_idx];
   assign sel_vec    = b_vec[sel_idx];

   int checks = 0, errors = 0;
   logic [VW-1:0] q_data[$];
   logic [5:0]    q_clr[$];
   string         q_tag[$];

   always #10 clk = ~clk;

   cpuack_ctrl #(.NUM_SRC(NS), .PRIO_W(PW), .VEC_W(VW), .CPU_ID(ID)) uut (
      .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_idx(raise_idx),
      .raise_prio(raise_prio), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
      .spur_vec(SPUR), .sel_idx(sel_idx), .sel_active(sel_active), .sel_edge(sel_edge),
      .sel_prio(sel_prio), .sel_vec(sel_vec), .clr_valid(clr_valid), .clr_idx(clr_idx),
      .clr_active(clr_active), .clr_pending(clr_pending), .cpu_irq(cpu_irq)
   );

   function automatic logic [5:0] mk_clr(bit v, bit a, bit p, int idx);
      return {v, a, p, 3'(idx)};
   endfunction

   // monitor: compare registered read results against the scoreboard
   always @(negedge clk) begin
      if (rst_n && reg_rvalid) begin
         checks++;
         if (q_data.size() == 0) begin
            errors++;
            $display("FAIL unexpected read result: actual %h expected none", reg_rdata);
         end else begin
            logic [VW-1:0] ed;
            logic [5:0] ec;
            string t;
            ed = q_data.pop_front();
            ec = q_clr.pop_front();
            t  = q_tag.pop_front();
            if (reg_rdata !== ed || {clr_valid, clr_active, clr_pending, clr_idx} !== ec) begin
               errors++;
               $display("FAIL %s: actual data %h clr %b expected data %h clr %b", t,
                        reg_rdata, {clr_valid, clr_active, clr_pending, clr_idx}, ed, ec);
            end
         end
      end
   end

   task automatic do_raise(int idx, int pr);
      @(negedge clk);
      raise_valid = 1'b1; raise_idx = IW'(idx); raise_prio = PW'(pr);
      @(negedge clk);
      raise_valid = 1'b0;
   endtask

   task automatic do_write(int a, int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = VW'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic do_read(int a, logic [VW-1:0] ed, logic [5:0] ec, string t);
      @(negedge clk);
      q_data.push_back(ed); q_clr.push_back(ec); q_tag.push_back(t);
      reg_rd = 1'b1; reg_addr = 2'(a);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chk_irq(bit e, string t);
      checks++;
      if (cpu_irq !== e) begin
         errors++;
         $display("FAIL %s: cpu_irq actual %b expected %b", t, cpu_irq, e);
      end
   endtask

   bit done = 1'b0;
   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NS; i++) begin
         b_act[i] = 1'b1; b_edge[i] = 1'b0; b_prio[i] = '0; b_vec[i] = '0;
      end
      b_vec[0] = 8'h0A; b_prio[0] = 4'd3;
      b_vec[1] = 8'h11; b_prio[1] = 4'd5;
      b_vec[3] = 8'h33; b_prio[3] = 4'd5; b_edge[3] = 1'b1;
      b_vec[4] = 8'h44; b_prio[4] = 4'd6; b_act[4] = 1'b0;
      b_vec[5] = 8'h55; b_prio[5] = 4'd1;
      b_vec[6] = 8'h66; b_prio[6] = 4'd7; b_edge[6] = 1'b1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_irq(1'b0, "R1 reset irq");
      do_read(0, 8'h0F, 6'b0, "R1 reset task priority");
      do_read(3, 8'(ID), 6'b0, "R11 identity read");
      do_read(1, SPUR, 6'b0, "R5 ack with empty raised set");

      do_raise(3, 5);
      chk_irq(1'b0, "R3 raise at or below task priority rejected");
      do_write(0, 8'h12);
      do_read(0, 8'h02, 6'b0, "R12 task priority low bits");
      do_write(3, 8'h77);
      do_read(3, 8'(ID), 6'b0, "R11 identity write ignored");

      do_raise(3, 5);
      chk_irq(1'b1, "R4 raise above task priority");
      do_raise(1, 5);
      do_raise(6, 7);
      do_raise(2, 2);
      do_read(1, 8'h66, mk_clr(1, 1, 1, 6), "R2 R8 highest priority edge ack");
      chk_irq(1'b0, "R4 raised not above in-service");
      do_write(2, 0);
      chk_irq(1'b1, "R9 EOI re-raises");
      do_read(1, 8'h11, mk_clr(1, 0, 0, 1), "R2 R6 tie to lowest index, level");
      chk_irq(1'b0, "R4 equal priority in service blocks");
      do_raise(4, 6);
      chk_irq(1'b1, "R4 higher than in-service");
      do_read(1, SPUR, mk_clr(1, 1, 0, 4), "R7 inactive source spurious");
      chk_irq(1'b0, "R7 spurious ack does not enter service");
      do_write(2, 0);
      chk_irq(1'b1, "R9 EOI empties service, raised wins");
      do_write(0, 6);
      chk_irq(1'b0, "R4 task priority masks raised");
      do_read(1, SPUR, mk_clr(1, 1, 1, 3), "R7 R8 priority not above task");
      do_read(1, SPUR, 6'b0, "R5 ack after raised set drained");
      do_write(2, 0);
      chk_irq(1'b0, "R10 EOI on empty service");
      do_write(0, 0);
      do_raise(5, 1);
      chk_irq(1'b1, "R10 service still empty after EOI");
      do_raise(5, 9);
      do_raise(0, 3);
      do_read(1, 8'h0A, mk_clr(1, 0, 0, 0), "R3 re-raise kept old priority");
      chk_irq(1'b0, "R4 lower raised behind service");
      do_read(1, 8'h55, mk_clr(1, 0, 0, 5), "R6 ack while irq low");
      do_write(2, 0);
      chk_irq(1'b0, "R9 raised set empty after EOI");

      repeat (3) @(negedge clk);
      checks++;
      if (q_data.size() != 0) begin
         errors++;
         $display("FAIL R6 missing read results: actual %0d pending expected 0", q_data.size());
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule